// File: doc/BRIEF.md
# Host-Side Byte FIFO Pair for a Two-Wire Bus Controller

This block sits between a register interface and the serial bus engine of a two-wire bus controller. Software pushes outgoing bytes into a transmit queue, one 32-bit write per byte. Bit 31 of that write tags the byte that closes the message. The bus engine drains the queue through a valid/ready handshake. Bytes the engine receives flow the other way into a receive queue, and software pops them one at a time.

A single control word does two jobs on write: it flushes either queue, and it sets a receive threshold. On read it returns the live receive occupancy and the threshold. Three level-type interrupt conditions come from the queue state:
- the receive queue holds at least the threshold;
- the transmit queue ran dry in the middle of a message;
- the receive queue is full.

The engine also gets an abort indication when it offers a byte that cannot be stored.

Top module: `hf_host_fifo_pair`

## Requirements
- R1: After reset both queues are empty, the occupancy field reads 0, the threshold reads 0, `eng_tx_valid` is low and all three interrupt outputs are low.
- R2: A transmit write stores bits 7:0 as the byte and bit 31 as the end-of-message tag. The engine receives the entries in write order with `eng_tx_last` equal to the tag.
- R3: Each queue holds 64 entries. A transmit write made while the transmit queue is full is dropped.
- R4: Control-word bits 22:16 read the number of bytes in the receive queue. `rxr_data` shows the oldest byte. A pop on an empty receive queue changes nothing.
- R5: Writing the control word with bit 31 set empties the receive queue, and bit 30 set empties the transmit queue, effective at the next clock edge. Both bits always read back as 0.
- R6: Control-word bits 13:8 hold the receive threshold, which is written by every control write. `irq_thld` is high while the threshold is nonzero and the occupancy is at or above it.
- R7: A threshold of 0 never raises `irq_thld`, whatever the occupancy.
- R8: `irq_tx_underrun` is high while the transmit queue is empty after the engine consumed a byte without the end tag. It drops when the queue is refilled. It stays low after a tagged byte is consumed or after a transmit flush.
- R9: When the receive queue holds 64 bytes, `irq_rx_full` is high and `eng_rx_ready` is low. A byte the engine offers then raises `eng_rx_abort` and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: 31 flush receive, 30 flush transmit, 13:8 threshold |
| ctrl_rdata | output | 32 | Control readback: 22:16 occupancy, 13:8 threshold |
| txw_wr | input | 1 | Transmit write strobe |
| txw_wdata | input | 32 | Bit 31 end tag, bits 7:0 byte |
| rxr_pop | input | 1 | Receive pop strobe |
| rxr_data | output | 8 | Oldest receive byte |
| eng_tx_valid | output | 1 | Transmit entry available to the engine |
| eng_tx_ready | input | 1 | Engine takes the entry |
| eng_tx_data | output | 8 | Transmit byte |
| eng_tx_last | output | 1 | End-of-message tag of the entry |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive queue can accept |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_abort | output | 1 | Offered byte dropped, receive queue full |
| irq_thld | output | 1 | Receive threshold reached |
| irq_tx_underrun | output | 1 | Transmit queue empty mid-message |
| irq_rx_full | output | 1 | Receive queue full |

## Verification
The assertions assume several things about the inputs. Strobes are single-cycle and driven between clock edges. The engine follows the handshake and takes a transmit entry only when `eng_tx_valid` is high. A pop on an empty receive queue, or a push into a full one, is legal input that must leave the count unchanged. The stimulus changes every input on the falling edge and holds each strobe for one cycle. It fills the receive queue exactly to 64 before it offers an overflowing byte. It flushes both queues between scenarios so that each table entry starts from a known occupancy.

// File: rtl/hf_pkg.sv
// Shared field positions and entry type for the host FIFO pair.
package hf_pkg;
    localparam int CTL_RXFLUSH_BIT = 31;
    localparam int CTL_TXFLUSH_BIT = 30;
    localparam int CTL_OCC_LSB     = 16;
    localparam int CTL_THLD_LSB    = 8;
    localparam int TXW_LAST_BIT    = 31;
    localparam int BYTE_W          = 8;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } tx_entry_t;
endpackage

// File: rtl/hf_fifo.sv
// Synchronous single-clock FIFO with flush.
// Assumes: DEPTH >= 2. Flush beats push and pop in the same cycle.
// Push when full and pop when empty are ignored.
module hf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: occupancy never exceeds the depth.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3: a push into a full queue leaves the count unchanged.
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> $stable(count));
    // R4: a pop from an empty queue leaves it empty.
    p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty);
    // R5: flush empties the queue at the next edge.
    p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/hf_txmsg_track.sv
// Tracks whether a transmit message is open.
// A message opens when the engine consumes an untagged byte and closes
// on a tagged byte or on a flush. Underrun is an open message with an
// empty transmit queue.
// Assumes: pop_fire is already qualified by a non-empty queue.
module hf_txmsg_track (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic pop_fire,
    input  logic pop_last,
    input  logic tx_empty,
    output logic underrun
);
    logic msg_open;

    // Open/close state of the message in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  msg_open <= 1'b0;
        else if (pop_fire)    msg_open <= !pop_last;
    end

    assign underrun = msg_open && tx_empty;

    // R8: consuming the tagged byte ends any underrun.
    p_last_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && pop_last && !flush) |=> !underrun);
    // R8: a flush clears underrun.
    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !underrun);
endmodule

// File: rtl/hf_rx_level.sv
// Holds the receive threshold and compares it with the live occupancy.
// Assumes: every control write updates the threshold field.
module hf_rx_level #(
    parameter int CW     = 7,
    parameter int THLD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [THLD_W-1:0] cfg_thld,
    input  logic [CW-1:0]     occ,
    output logic [THLD_W-1:0] thld_q,
    output logic              hit
);
    localparam int XW = (CW > THLD_W) ? CW : THLD_W;

    // Threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)      thld_q <= '0;
        else if (cfg_wr) thld_q <= cfg_thld;
    end

    // Level compare; a zero threshold disables the condition.
    always_comb begin
        hit = (thld_q != '0) && (XW'(occ) >= XW'(thld_q));
    end
endmodule

// File: rtl/hf_host_fifo_pair.sv
// Host-side data path of a two-wire bus controller: a transmit queue of
// tagged bytes, a receive queue, flush control, threshold and the
// interrupt conditions derived from them.
// Assumes: single clock; register strobes last one cycle.
module hf_host_fifo_pair
    import hf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int THLD_W = 6,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int TXE_W = $bits(tx_entry_t)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] ctrl_rdata,
    input  logic        txw_wr,
    input  logic [31:0] txw_wdata,
    input  logic        rxr_pop,
    output logic [7:0]  rxr_data,
    output logic        eng_tx_valid,
    input  logic        eng_tx_ready,
    output logic [7:0]  eng_tx_data,
    output logic        eng_tx_last,
    input  logic        eng_rx_valid,
    output logic        eng_rx_ready,
    input  logic [7:0]  eng_rx_data,
    output logic        eng_rx_abort,
    output logic        irq_thld,
    output logic        irq_tx_underrun,
    output logic        irq_rx_full
);
    logic              rx_flush, tx_flush;
    tx_entry_t         tx_in, tx_head;
    logic [TXE_W-1:0]  tx_head_raw;
    logic [CW-1:0]     tx_count, rx_count;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_fire;
    logic [THLD_W-1:0] thld_q;
    logic              unused_bits;

    assign rx_flush = cfg_wr && cfg_wdata[CTL_RXFLUSH_BIT];
    assign tx_flush = cfg_wr && cfg_wdata[CTL_TXFLUSH_BIT];
    assign tx_in    = '{last: txw_wdata[TXW_LAST_BIT], data: txw_wdata[BYTE_W-1:0]};
    assign unused_bits = ^{cfg_wdata, txw_wdata, tx_count, tx_full};

    hf_fifo #(.WIDTH(TXE_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(txw_wr), .push_data(tx_in),
        .pop(eng_tx_ready), .head(tx_head_raw),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    hf_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_valid), .push_data(eng_rx_data),
        .pop(rxr_pop), .head(rxr_data),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    assign tx_head      = tx_entry_t'(tx_head_raw);
    assign eng_tx_valid = !tx_empty;
    assign eng_tx_data  = tx_head.data;
    assign eng_tx_last  = tx_head.last;
    assign tx_fire      = eng_tx_valid && eng_tx_ready && !tx_flush;

    hf_txmsg_track u_track (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .pop_fire(tx_fire), .pop_last(tx_head.last),
        .tx_empty(tx_empty), .underrun(irq_tx_underrun)
    );

    hf_rx_level #(.CW(CW), .THLD_W(THLD_W)) u_level (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_thld(cfg_wdata[CTL_THLD_LSB +: THLD_W]),
        .occ(rx_count), .thld_q(thld_q), .hit(irq_thld)
    );

    assign eng_rx_ready = !rx_full;
    assign eng_rx_abort = eng_rx_valid && rx_full;
    assign irq_rx_full  = rx_full;

    // Control readback; flush bits always read as zero.
    always_comb begin
        ctrl_rdata = '0;
        ctrl_rdata[CTL_OCC_LSB +: CW]      = rx_count;
        ctrl_rdata[CTL_THLD_LSB +: THLD_W] = thld_q;
    end

    // R6: threshold condition implies a non-empty receive queue.
    p_thld_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_thld |-> !rx_empty);
    // R7: a zero threshold keeps the condition low.
    p_thld_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thld_q == '0) |-> !irq_thld);
    // R9: an aborted byte is not stored.
    p_abort_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_abort && !rxr_pop && !rx_flush) |=> $stable(rx_count));
    // R8: underrun only with nothing for the engine to send.
    p_underrun_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_underrun |-> !eng_tx_valid);
endmodule

// File: tb/hf_host_fifo_pair_tb_top.sv
module hf_host_fifo_pair_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        txw_wr = 1'b0;
    logic [31:0] txw_wdata = '0;
    logic        rxr_pop = 1'b0;
    logic [7:0]  rxr_data;
    logic        eng_tx_valid, eng_tx_last, eng_rx_ready, eng_rx_abort;
    logic        eng_tx_ready = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_rx_valid = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        irq_thld, irq_tx_underrun, irq_rx_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hf_host_fifo_pair dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ctrl_rdata(ctrl_rdata), .txw_wr(txw_wr), .txw_wdata(txw_wdata),
        .rxr_pop(rxr_pop), .rxr_data(rxr_data),
        .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
        .eng_tx_data(eng_tx_data), .eng_tx_last(eng_tx_last),
        .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
        .eng_rx_data(eng_rx_data), .eng_rx_abort(eng_rx_abort),
        .irq_thld(irq_thld), .irq_tx_underrun(irq_tx_underrun),
        .irq_rx_full(irq_rx_full)
    );

    // Threshold table: {threshold[5:0], bytes pushed[6:0], expected irq_thld}.
    localparam logic [13:0] VEC [8] = '{
        {6'd0,  7'd5,  1'b0},
        {6'd3,  7'd2,  1'b0},
        {6'd3,  7'd3,  1'b1},
        {6'd3,  7'd10, 1'b1},
        {6'd63, 7'd62, 1'b0},
        {6'd63, 7'd63, 1'b1},
        {6'd1,  7'd1,  1'b1},
        {6'd0,  7'd64, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [31:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic txw(input logic [7:0] d, input logic last);
        txw_wr = 1'b1; txw_wdata = {last, 23'd0, d};
        @(negedge clk);
        txw_wr = 1'b0; txw_wdata = '0;
    endtask

    task automatic eng_push(input logic [7:0] d);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic eng_take();
        eng_tx_ready = 1'b1;
        @(negedge clk);
        eng_tx_ready = 1'b0;
    endtask

    task automatic host_pop();
        rxr_pop = 1'b1;
        @(negedge clk);
        rxr_pop = 1'b0;
    endtask

    function automatic logic [31:0] occ(input logic [31:0] r);
        return {25'd0, r[22:16]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 occupancy", occ(ctrl_rdata), 0);
        chk("R1 ctrl readback", ctrl_rdata, 0);
        chk("R1 tx valid", {31'd0, eng_tx_valid}, 0);
        chk("R1 irqs", {29'd0, irq_thld, irq_tx_underrun, irq_rx_full}, 0);

        // R6 R7 R4: table walk over threshold and fill level
        foreach (VEC[i]) begin
            logic [5:0] th;
            logic [6:0] n;
            th = VEC[i][13:8];
            n  = VEC[i][7:1];
            cfg((32'd1 << 31) | (32'(th) << 8));
            for (int k = 0; k < int'(n); k++) eng_push(8'(k));
            chk("R4 table occupancy", occ(ctrl_rdata), 32'(n));
            chk("R6 R7 table irq_thld", {31'd0, irq_thld}, {31'd0, VEC[i][0]});
            chk("R6 threshold readback", {26'd0, ctrl_rdata[13:8]}, 32'(th));
        end

        // R9: queue is full from the last table entry
        chk("R9 full flag", {31'd0, irq_rx_full}, 1);
        chk("R9 ready low", {31'd0, eng_rx_ready}, 0);
        eng_rx_valid = 1'b1; eng_rx_data = 8'hEE;
        #1;
        chk("R9 abort", {31'd0, eng_rx_abort}, 1);
        @(negedge clk);
        eng_rx_valid = 1'b0;
        chk("R9 count held", occ(ctrl_rdata), 64);

        // R5: receive flush and flush bits readback
        cfg(32'h8000_0000);
        chk("R5 rx flushed", occ(ctrl_rdata), 0);
        chk("R5 flush bits read 0", {30'd0, ctrl_rdata[31:30]}, 0);
        chk("R9 full cleared", {31'd0, irq_rx_full}, 0);

        // R4: receive order and pop on empty
        for (int k = 0; k < 4; k++) eng_push(8'h5A ^ 8'(k));
        for (int k = 0; k < 4; k++) begin
            chk("R4 rx order", {24'd0, rxr_data}, {24'd0, 8'h5A ^ 8'(k)});
            host_pop();
        end
        chk("R4 drained", occ(ctrl_rdata), 0);
        host_pop();
        chk("R4 pop empty no effect", occ(ctrl_rdata), 0);

        // R2: transmit order and end tag
        txw(8'h11, 1'b0); txw(8'h22, 1'b0); txw(8'h33, 1'b1);
        chk("R2 first byte", {23'd0, eng_tx_last, eng_tx_data}, 32'h011);
        eng_take();
        chk("R2 second byte", {23'd0, eng_tx_last, eng_tx_data}, 32'h022);
        eng_take();
        chk("R2 tagged byte", {23'd0, eng_tx_last, eng_tx_data}, 32'h133);
        eng_take();
        chk("R2 drained", {31'd0, eng_tx_valid}, 0);
        chk("R8 no underrun after tag", {31'd0, irq_tx_underrun}, 0);

        // R8: underrun mid-message
        txw(8'hA1, 1'b0);
        eng_take();
        chk("R8 underrun raised", {31'd0, irq_tx_underrun}, 1);
        txw(8'hA2, 1'b1);
        chk("R8 refill drops underrun", {31'd0, irq_tx_underrun}, 0);
        eng_take();
        chk("R8 closed by tag", {31'd0, irq_tx_underrun}, 0);

        // R3: 65 writes, only 64 stored
        for (int k = 0; k < 65; k++) txw(8'(k), 1'b0);
        begin
            int got;
            logic [7:0] lastd;
            got = 0; lastd = '0;
            eng_tx_ready = 1'b1;
            while (eng_tx_valid && got < 100) begin
                lastd = eng_tx_data;
                got++;
                @(negedge clk);
            end
            eng_tx_ready = 1'b0;
            chk("R3 tx depth", 32'(got), 64);
            chk("R3 overflow dropped", {24'd0, lastd}, 32'd63);
        end
        chk("R8 underrun after untagged drain", {31'd0, irq_tx_underrun}, 1);

        // R5 R8: transmit flush
        cfg(32'h4000_0000);
        chk("R8 flush clears underrun", {31'd0, irq_tx_underrun}, 0);
        txw(8'h01, 1'b0); txw(8'h02, 1'b0);
        cfg(32'h4000_0000);
        chk("R5 tx flushed", {31'd0, eng_tx_valid}, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule